// File: doc/BRIEF.md
# Single-Slope Ramp Converter Sequencer

This block sequences the digital half of a single-slope analog-to-digital converter. A start request opens a clock gate; from then on an internal counter advances once per clock while an external integrator ramps upward. When an external comparator signals that the ramp has caught up with the analog input, the gate shuts, the count is captured as the conversion result and a one-cycle valid strobe is issued.

Each conversion is closed by a discharge phase. A discharge output stays high for a fixed number of clocks to empty the ramp capacitor, and the counter is cleared. Only after that phase ends does the block accept a new start. Because counting is stopped by the comparator, a larger input takes more clocks to convert. If the counter reaches its top value before the comparator trips, the conversion is cut short and an overflow flag is raised.

Top module: `ramp_adc_seq`

## Requirements
- R1: Out of reset, gate_o, discharge_o, valid_o and overflow_o are low and result_o is zero.
- R2: A start_i high while the block is idle opens gate_o at the next clock edge, and the counter begins at zero. start_i never opens the gate any other way.
- R3: With a ramp that rises one code per open-gate clock, a conversion of input code V (0 to 2^CNT_W-1) keeps gate_o high for exactly V+1 clocks and yields result_o = V.
- R4: In a clock where gate_o and cmp_i are both high, the count is captured at the edge: gate_o drops, result_o takes the count and valid_o is high for exactly one cycle.
- R5: If the count is all ones and cmp_i is low, the conversion ends with result_o all ones and overflow_o high. If cmp_i is high at that same count, the result is valid and overflow_o stays low.
- R6: discharge_o goes high in the cycle after capture, together with valid_o. It stays high for exactly DISCH_CYC clocks (default 4), and during that time gate_o is low.
- R7: start_i is ignored while gate_o or discharge_o is high. It neither restarts nor lengthens the conversion in progress.
- R8: overflow_o holds its value until the next accepted start, which clears it.
- R9: gate_o and discharge_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion (acted on only when idle) |
| cmp_i | input | 1 | Comparator: high when the ramp has reached the input |
| gate_o | output | 1 | Clock gate open / ramp running |
| discharge_o | output | 1 | Ramp capacitor discharge command |
| result_o | output | CNT_W | Captured conversion count |
| valid_o | output | 1 | One-cycle strobe when result_o is updated |
| overflow_o | output | 1 | Last conversion hit full count without a comparator trip |

## Verification
The hardest case to reach is the boundary at the top count. Here the comparator tripping exactly at the all-ones count must win over the overflow exit, while an input one step beyond the counter's range must take it. The bench's ideal ramp model accepts input codes wider than the counter. This lets it drive both the full-scale code and an out-of-range code into the same top-count clock and compare the flag and the result. Start requests are also toggled throughout counting and discharge to show that they cannot disturb a conversion in progress.

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq #(
  parameter int CNT_W     = 10,
  parameter int DISCH_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             gate_o,
  output logic             discharge_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             overflow_o
);

  localparam int DW = (DISCH_CYC < 2) ? 1 : $clog2(DISCH_CYC);
  localparam logic [DW-1:0] DLAST = DW'(DISCH_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_DISCH} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    dcnt;
  logic             at_top;

  assign gate_o      = (state == S_COUNT);
  assign discharge_o = (state == S_DISCH);
  assign at_top      = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      dcnt       <= '0;
      result_o   <= '0;
      valid_o    <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            state      <= S_COUNT;
            overflow_o <= 1'b0;
          end
        end
        S_COUNT: begin
          if (cmp_i || at_top) begin
            state      <= S_DISCH;
            result_o   <= cnt;
            valid_o    <= 1'b1;
            overflow_o <= !cmp_i;
            dcnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DISCH: begin
          cnt <= '0;
          if (dcnt == DLAST) state <= S_IDLE;
          else dcnt <= dcnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_gate_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(start_i));
  assert_trip_closes_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && cmp_i) |=> (!gate_o && valid_o));
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_ovf_full_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && overflow_o) |-> (&result_o));
  assert_disch_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discharge_o) |-> valid_o);
  assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !$rose(gate_o)) |-> $stable(overflow_o));
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o && discharge_o));

endmodule

// File: tb/ramp_adc_seq_tb.sv
module ramp_adc_seq_tb_top;
  localparam int CNT_W = 10;
  localparam int DISCH_CYC = 4;
  localparam int TOP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic gate, disch, valid, ovf;
  logic [CNT_W-1:0] res;

  int vin = 0;
  int ramp;
  int errors = 0;
  int checks = 0;
  bit noisy = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ramp <= 0;
    else if (disch) ramp <= 0;
    else if (gate) ramp <= ramp + 1;
  end
  assign cmp = (ramp >= vin);

  ramp_adc_seq #(.CNT_W(CNT_W), .DISCH_CYC(DISCH_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .gate_o(gate), .discharge_o(disch), .result_o(res),
    .valid_o(valid), .overflow_o(ovf));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int v, input int exp_res, input int exp_ovf);
    int gcnt = 0, dcnt = 0, vcnt = 0, rres = 0, rovf = 0, ovf_first = -1;
    bit seen_d = 1'b0, overlap = 1'b0;
    vin = v;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 gate opens after start", int'(gate), 1);
    for (int i = 0; i < 3000; i++) begin
      if (gate && disch) overlap = 1'b1;
      if (gate) begin
        if (gcnt == 0) ovf_first = int'(ovf);
        gcnt++;
      end
      if (disch) begin
        seen_d = 1'b1;
        dcnt++;
      end
      if (valid) begin
        vcnt++;
        rres = int'(res);
        rovf = int'(ovf);
        chk("R6 discharge starts with valid", int'(disch), 1);
      end
      if (seen_d && !disch) break;
      if (noisy) start = gate || (disch && dcnt == 2);
      @(negedge clk);
      if (noisy && !gate && !disch) start = 1'b0;
    end
    start = 1'b0;
    chk("R3 gate cycles", gcnt, (exp_ovf != 0) ? TOP + 1 : v + 1);
    chk("R3 result", rres, exp_res);
    chk("R4 single valid", vcnt, 1);
    chk("R5 overflow flag", rovf, exp_ovf);
    chk("R6 discharge length", dcnt, DISCH_CYC);
    chk("R8 overflow cleared at start", ovf_first, 0);
    chk("R9 no overlap", int'(overlap), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 no restart after busy", int'(gate), 0);
    end
    chk("R8 overflow held", int'(ovf), exp_ovf);
  endtask

  task automatic reset_test();
    chk("R1 gate", int'(gate), 0);
    chk("R1 discharge", int'(disch), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 overflow", int'(ovf), 0);
    chk("R1 result", int'(res), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_test();
    convert(0, 0, 0);
    convert(1, 1, 0);
    convert(5, 5, 0);
    convert(300, 300, 0);
    convert(TOP, TOP, 0);
    convert(2000, TOP, 1);
    convert(37, 37, 0);
    noisy = 1'b1;
    convert(12, 12, 0);
    noisy = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule